// File: doc/BRIEF.md
# Core Reset and Processing-State Sequencer

This block decides which processing state a small processor core occupies: reset, normal, exception, debug or wait. Three sources can hold the core in reset. The first is an active-low external reset pin. The second is a watchdog timeout. The third is a periodic-timer reset. The core stays in reset for as long as any of these is active.

When the last source lets go, the block does four things in one clock edge:
- It pulses a one-cycle register-initialisation strobe.
- It presents the reset values for the address-modifier, status and operating-mode registers.
- It captures the two chip-mode pins.
- It loads a start address chosen by the source that caused the reset.

The core then enters the debug state if a debug request is pending, and the normal state otherwise.

Outside reset, the block handles the remaining state changes. An enabled interrupt moves the core through a one-cycle exception state. A debug request holds it in debug. A wait request parks it in a low-power wait state, which only an enabled interrupt can end.

Top module: `core_state_seq`

## Requirements
- R1: The `state` output uses these codes: 0 reset, 1 normal, 2 exception, 3 debug, 4 wait. No other value ever appears. While `rst_pin_n` is low, `state` is 0, `init_stb` is 0 and `cause` is 3.
- R2: The external pin passes through a two-flop synchronizer. After `rst_pin_n` rises, `state` stays 0 after the first and second rising clock edges. It leaves 0 at the third edge, provided no other cause is active.
- R3: If `wdog_zero` or `tmr_reset` is high at a clock edge, `state` is 0 after that edge. The core stays in reset through every edge at which any cause is active.
- R4: `cause` records the source of the current or last reset, coded 3 pin, 2 watchdog, 1 timer. If several sources are active within one reset episode, the highest code seen is kept.
- R5: At release, `start_addr` loads `VEC_PIN`, `VEC_WDOG` or `VEC_TMR` according to `cause`, and holds that value until the next release.
- R6: `init_stb` is high for exactly the one cycle that follows the edge at which the core leaves reset.
- R7: At release, `mode_bits` captures `mode_pins` and holds that value afterwards. `opmode_init` is `mode_bits` zero-extended, so every other operating-mode bit reads 0.
- R8: `mod_init` is all ones. `stat_init` is 0x0300: the interrupt-mask bits 9 and 8 are set, and the loop flag (bit 15) and the condition codes (bits 7:0) are cleared.
- R9: At release, the core goes to debug (3) if `dbg_req` is high, and to normal (1) otherwise.
- R10: From normal, the next state is chosen in this priority order:
  - If `irq_req` and `irq_en` are both high, the core enters exception (2).
  - Otherwise, if `dbg_req` is high, it enters debug (3).
  - Otherwise, if `wait_req` is high, it enters wait (4).

  Exception returns to normal after one cycle. Debug returns to normal at the first edge where `dbg_req` is low.
- R11: In wait, the core moves to exception only when `irq_req` and `irq_en` are both high at an edge. An interrupt request that is not enabled is ignored, and the core stays in wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous assert |
| wdog_zero | input | 1 | Watchdog reached zero (synchronous) |
| tmr_reset | input | 1 | Periodic-timer reset request (synchronous) |
| mode_pins | input | MODE_W | Chip-mode select pins |
| dbg_req | input | 1 | Debug request |
| wait_req | input | 1 | Request to enter the wait state |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable |
| state | output | 3 | Processing-state code |
| init_stb | output | 1 | Register-initialisation strobe |
| cause | output | 2 | Reset-cause code |
| mode_bits | output | MODE_W | Captured chip-mode bits |
| start_addr | output | ADDR_W | Start vector for the last release |
| mod_init | output | DATA_W | Modifier register reset value |
| stat_init | output | DATA_W | Status register reset value |
| opmode_init | output | DATA_W | Operating-mode register reset value |

## Verification
The hardest case to reach from the ports is a reset episode in which several sources overlap and end in a staggered order. In that case the kept cause must stay at the highest source seen, even after that source has gone quiet and a lower one is still holding the core in reset.

Directed steps build this case explicitly: the watchdog and timer assert together, then the timer alone holds reset, then the release happens with a debug request pending. Random runs then mix short pin pulses with sparse watchdog and timer pulses, so that overlapping and back-to-back episodes occur many times.

// File: rtl/core_state_seq.sv
module core_state_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int MODE_W = 2,
  parameter logic [ADDR_W-1:0] VEC_PIN  = 'h0000,
  parameter logic [ADDR_W-1:0] VEC_WDOG = 'h0002,
  parameter logic [ADDR_W-1:0] VEC_TMR  = 'h0004
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              wdog_zero,
  input  logic              tmr_reset,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              dbg_req,
  input  logic              wait_req,
  input  logic              irq_req,
  input  logic              irq_en,
  output logic [2:0]        state,
  output logic              init_stb,
  output logic [1:0]        cause,
  output logic [MODE_W-1:0] mode_bits,
  output logic [ADDR_W-1:0] start_addr,
  output logic [DATA_W-1:0] mod_init,
  output logic [DATA_W-1:0] stat_init,
  output logic [DATA_W-1:0] opmode_init
);
  localparam logic [2:0] ST_RST = 3'd0, ST_NRM = 3'd1, ST_EXC = 3'd2,
                         ST_DBG = 3'd3, ST_WAIT = 3'd4;
  localparam logic [1:0] C_NONE = 2'd0, C_TMR = 2'd1, C_WDOG = 2'd2, C_PIN = 2'd3;
  localparam logic [DATA_W-1:0] STAT_RST = DATA_W'(16'h0300);

  logic [1:0] sync;
  logic [1:0] cur;
  logic [2:0] nxt;
  logic       irq_ok, release_now;
  logic [ADDR_W-1:0] vec;

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) sync <= '0;
    else            sync <= {sync[0], 1'b1};

  assign cur = !sync[1] ? C_PIN : wdog_zero ? C_WDOG : tmr_reset ? C_TMR : C_NONE;
  assign irq_ok = irq_req && irq_en;
  assign release_now = (state == ST_RST) && (cur == C_NONE);
  assign vec = (cause == C_PIN) ? VEC_PIN : (cause == C_WDOG) ? VEC_WDOG : VEC_TMR;

  always_comb begin
    nxt = state;
    if (cur != C_NONE) nxt = ST_RST;
    else
      case (state)
        ST_RST:  nxt = dbg_req ? ST_DBG : ST_NRM;
        ST_NRM:  nxt = irq_ok ? ST_EXC : dbg_req ? ST_DBG : wait_req ? ST_WAIT : ST_NRM;
        ST_EXC:  nxt = ST_NRM;
        ST_DBG:  nxt = dbg_req ? ST_DBG : ST_NRM;
        ST_WAIT: nxt = irq_ok ? ST_EXC : ST_WAIT;
        default: nxt = ST_RST;
      endcase
  end

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      state      <= ST_RST;
      init_stb   <= 1'b0;
      cause      <= C_PIN;
      mode_bits  <= '0;
      start_addr <= '0;
    end else begin
      state    <= nxt;
      init_stb <= release_now;
      if (cur != C_NONE && (state != ST_RST || cur > cause)) cause <= cur;
      if (release_now) begin
        mode_bits  <= mode_pins;
        start_addr <= vec;
      end
    end

  assign mod_init    = '1;
  assign stat_init   = STAT_RST;
  assign opmode_init = DATA_W'(mode_bits);
endmodule

// File: rtl/core_state_seq_chk.sv
module core_state_seq_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_PIN  = 'h0000,
  parameter logic [ADDR_W-1:0] VEC_WDOG = 'h0002,
  parameter logic [ADDR_W-1:0] VEC_TMR  = 'h0004
) (
  input logic              clk,
  input logic              rst_pin_n,
  input logic              wdog_zero,
  input logic              tmr_reset,
  input logic              irq_req,
  input logic              irq_en,
  input logic [2:0]        state,
  input logic              init_stb,
  input logic [1:0]        cause,
  input logic [ADDR_W-1:0] start_addr
);
  // R1
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_pin_n) state <= 3'd4);
  // R3
  wdog_reset_chk: assert property (@(posedge clk) disable iff (!rst_pin_n) wdog_zero |=> state == 3'd0);
  // R3
  tmr_reset_chk: assert property (@(posedge clk) disable iff (!rst_pin_n) tmr_reset |=> state == 3'd0);
  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_pin_n) init_stb |=> !init_stb);
  // R6
  strobe_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(init_stb) |-> $past(state) == 3'd0 && state != 3'd0);
  // R5
  vector_sel_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    init_stb |-> start_addr == ((cause == 2'd3) ? VEC_PIN : (cause == 2'd2) ? VEC_WDOG : VEC_TMR));
  // R11
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (state == 3'd4 && !(irq_req && irq_en) && !wdog_zero && !tmr_reset) |=> state == 3'd4);
endmodule

bind core_state_seq core_state_seq_chk #(.ADDR_W(ADDR_W), .VEC_PIN(VEC_PIN),
  .VEC_WDOG(VEC_WDOG), .VEC_TMR(VEC_TMR)) chk (.*);

// File: tb/core_state_seq_test.sv
`timescale 1ns/1ps
module core_state_seq_test;
  localparam logic [15:0] VP = 16'h0000, VW = 16'h0002, VT = 16'h0004;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_pin_n = 0, wdog_zero = 0, tmr_reset = 0, dbg_req = 0, wait_req = 0, irq_req = 0, irq_en = 0;
  logic [1:0] mode_pins = 0;
  logic [2:0] state;
  logic init_stb;
  logic [1:0] cause, mode_bits;
  logic [15:0] start_addr, mod_init, stat_init, opmode_init;
  int checks = 0, errors = 0;
  bit done = 0;

  core_state_seq uut (.*);

  logic [1:0] ms;
  logic [2:0] mst;
  logic       minit;
  logic [1:0] mcause, mmode;
  logic [15:0] mstart;
  logic [1:0] mc;
  assign mc = !ms[1] ? 2'd3 : wdog_zero ? 2'd2 : tmr_reset ? 2'd1 : 2'd0;

  always @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      ms <= 0; mst <= 0; minit <= 0; mcause <= 3; mmode <= 0; mstart <= 0;
    end else begin
      ms <= {ms[0], 1'b1};
      minit <= (mst == 0 && mc == 0);
      if (mc != 0) begin
        mst <= 0;
        if (mst != 0 || mc > mcause) mcause <= mc;
      end else if (mst == 0) begin
        mst <= dbg_req ? 3 : 1;
        mmode <= mode_pins;
        mstart <= (mcause == 3) ? VP : (mcause == 2) ? VW : VT;
      end else if (mst == 1)
        mst <= (irq_req && irq_en) ? 2 : dbg_req ? 3 : wait_req ? 4 : 1;
      else if (mst == 2) mst <= 1;
      else if (mst == 3) mst <= dbg_req ? 3 : 1;
      else if (mst == 4) mst <= (irq_req && irq_en) ? 2 : 4;
    end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(state, mst, "R10 state");
    chk(init_stb, minit, "R6 strobe");
    chk(cause, mcause, "R4 cause");
    chk(start_addr, mstart, "R5 vector");
    chk(mode_bits, mmode, "R7 mode");
    chk(opmode_init, {14'd0, mmode}, "R7 opmode");
    chk(mod_init, 16'hFFFF, "R8 modifier");
    chk(stat_init, 16'h0300, "R8 status");
  end

  task automatic step(); @(negedge clk); #1; endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; done = 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd19));
    mode_pins = 2'b10;
    step(); step();
    chk(state, 0, "R1 reset state"); chk(cause, 3, "R1 cause"); chk(init_stb, 0, "R1 strobe");
    rst_pin_n = 1;
    @(negedge clk); chk(state, 0, "R2 edge1");
    @(negedge clk); chk(state, 0, "R2 edge2");
    @(negedge clk); chk(state, 1, "R2 exit"); chk(init_stb, 1, "R6 pulse");
    chk(start_addr, VP, "R5 pin vector"); chk(mode_bits, 2'b10, "R7 capture");
    #1 mode_pins = 2'b01;
    @(negedge clk); chk(init_stb, 0, "R6 single"); chk(mode_bits, 2'b10, "R7 hold");
    #1 wdog_zero = 1; tmr_reset = 1;
    step(); wdog_zero = 0;
    chk(state, 0, "R3 wdog"); chk(cause, 2, "R4 wdog over tmr");
    step(); step(); chk(state, 0, "R3 held by tmr"); chk(cause, 2, "R4 kept");
    tmr_reset = 0; dbg_req = 1;
    step(); chk(state, 3, "R9 debug release"); chk(start_addr, VW, "R5 wdog vector");
    chk(mode_bits, 2'b01, "R7 recapture");
    dbg_req = 0;
    step(); chk(state, 1, "R10 debug exit");
    tmr_reset = 1; step(); tmr_reset = 0; chk(cause, 1, "R4 tmr");
    step(); chk(start_addr, VT, "R5 tmr vector"); chk(state, 1, "R9 normal");
    wait_req = 1; step(); wait_req = 0; chk(state, 4, "R10 wait");
    irq_req = 1; irq_en = 0;
    step(); step(); step(); chk(state, 4, "R11 masked irq ignored");
    irq_en = 1; step(); chk(state, 2, "R11 wake");
    irq_req = 0; step(); chk(state, 1, "R10 exc return");
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(63) == 0) rst_pin_n = 0;
      else if (!rst_pin_n && $urandom_range(2) == 0) rst_pin_n = 1;
      wdog_zero = ($urandom_range(39) == 0);
      tmr_reset = ($urandom_range(39) == 0);
      dbg_req   = ($urandom_range(7) == 0);
      wait_req  = ($urandom_range(3) == 0);
      irq_req   = ($urandom_range(3) == 0);
      irq_en    = $urandom_range(1);
      mode_pins = 2'($urandom_range(3));
      step();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule